// File: doc/BRIEF.md
# Bipolar Line Code Decoder

This block takes a bipolar line signal that has already been split into two rails: one input pulses for a positive mark and the other for a negative mark. It turns that signal back into unipolar NRZ data, one bit for each symbol. A symbol is presented on the rails together with a single-cycle symbol enable. Cycles without the enable are idle and the rails are ignored in those cycles.

A mode input selects the decoding rule. In AMI mode, every mark that repeats the previous mark's polarity is reported as a line code violation. In B3ZS mode, a same-polarity mark can instead be recognised as the violation pulse of a zero substitution. The first form is two spaces followed by the violation pulse. The second form is an alternating pulse, a space, then the violation pulse. Either form is restored to three zeros. To clear the leading pulse of the second form after the fact, decoded bits pass through a short delay line before they are released. Repeats that fit neither form are reported on a violation strobe.

Top module: `bipolar_decoder`

## Requirements
- R1: While reset is asserted, and after it is released before any symbol arrives, `data_out`, `data_vld` and `viol_out` are all 0.
- R2: A mark (exactly one rail high) decodes to 1 and a space (both rails low) decodes to 0. The bit for symbol k is presented on `data_out` in the cycle after the symbol enable of symbol k+3.
- R3: `data_vld` is 1 for exactly the one cycle after each symbol enable, starting from the fourth symbol after reset. It is 0 in all other cycles.
- R4: In AMI mode (`mode_b3zs`=0), a mark with the same polarity as the last mark raises `viol_out` in the cycle after its enable and decodes to 1. No substitution is made.
- R5: A symbol with both rails high raises `viol_out` and decodes to 1. It does not change the stored last-mark polarity.
- R6: The first single-rail mark after reset never raises `viol_out`, whatever its polarity.
- R7: In B3ZS mode, a same-polarity mark preceded by two spaces (the 00V form) decodes to 0 and raises no violation. All three symbols come out as 0.
- R8: In B3ZS mode, a same-polarity mark preceded by a space and, before that, an alternating mark (the B0V form) decodes to 0. The alternating mark is rewritten to 0, so all three come out as 0, and no violation is raised.
- R9: In B3ZS mode, a same-polarity mark that fits neither substitution form raises `viol_out` and decodes to 1.
- R10: Cycles without `sym_en` leave `data_out` unchanged and keep `data_vld` and `viol_out` at 0, whatever the rails or mode carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_en | input | 1 | One symbol is present on the rails in this cycle |
| rail_p | input | 1 | Positive pulse rail |
| rail_n | input | 1 | Negative pulse rail |
| mode_b3zs | input | 1 | 1 = B3ZS decoding, 0 = plain AMI decoding |
| data_out | output | 1 | Decoded NRZ bit, delayed by three symbols |
| data_vld | output | 1 | `data_out` holds a new bit in this cycle |
| viol_out | output | 1 | Line code violation for the symbol of the previous enable |

## Verification
The violation strobe refers to the symbol whose enable came in the previous cycle. The bench therefore samples `viol_out` just after the clock edge that took that symbol. The data bit comes out three enables later: the bench keeps an array of expected bits indexed by symbol and compares `data_out` with entry k-3 at the edge of symbol k. This ordering allows a B0V to rewrite entry k-2 before that entry is due. In idle cycles inserted between symbols, the bench checks that `data_out` holds and that both strobes stay low.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

  typedef enum logic [1:0] {
    SK_SPACE = 2'd0,
    SK_POS   = 2'd1,
    SK_NEG   = 2'd2,
    SK_BOTH  = 2'd3
  } sym_kind_t;

endpackage

// File: rtl/bpd_classify.sv
module bpd_classify
  import bpd_pkg::*;
(
  input  logic      rail_p,
  input  logic      rail_n,
  output sym_kind_t kind
);

  always_comb begin
    unique case ({rail_p, rail_n})
      2'b10:   kind = SK_POS;
      2'b01:   kind = SK_NEG;
      2'b11:   kind = SK_BOTH;
      default: kind = SK_SPACE;
    endcase
  end

endmodule

// File: rtl/bpd_judge.sv
module bpd_judge
  import bpd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sym_en,
  input  logic      mode_b3zs,
  input  sym_kind_t kind,
  output logic      bit_dec,
  output logic      viol_now,
  output logic      clr_back
);

  // polarity memory
  logic have_pol_q, have_pol_d;
  logic last_neg_q, last_neg_d;
  // two-symbol look-behind (kind and "was alternating mark")
  sym_kind_t h1_q, h1_d, h2_q, h2_d;
  logic h1_alt_q, h1_alt_d, h2_alt_q, h2_alt_d;

  logic is_mark, is_neg, repeat_c, form_00v, form_b0v, subst, cur_alt;

  always_comb begin
    is_mark  = (kind == SK_POS) || (kind == SK_NEG);
    is_neg   = (kind == SK_NEG);
    repeat_c = is_mark && have_pol_q && (is_neg == last_neg_q);
    form_00v = (h1_q == SK_SPACE) && (h2_q == SK_SPACE);
    form_b0v = (h1_q == SK_SPACE) && h2_alt_q;
    subst    = mode_b3zs && repeat_c && (form_00v || form_b0v);
    cur_alt  = is_mark && !repeat_c;

    bit_dec  = (kind != SK_SPACE) && !subst;
    viol_now = (kind == SK_BOTH) || (repeat_c && !subst);
    clr_back = subst && form_b0v;
  end

  always_comb begin
    have_pol_d = have_pol_q;
    last_neg_d = last_neg_q;
    h1_d       = h1_q;
    h2_d       = h2_q;
    h1_alt_d   = h1_alt_q;
    h2_alt_d   = h2_alt_q;
    if (sym_en) begin
      h2_d     = h1_q;
      h1_d     = kind;
      h2_alt_d = h1_alt_q;
      h1_alt_d = cur_alt;
      if (is_mark) begin
        have_pol_d = 1'b1;
        last_neg_d = is_neg;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_pol_q <= 1'b0;
      last_neg_q <= 1'b0;
      h1_q       <= SK_SPACE;
      h2_q       <= SK_SPACE;
      h1_alt_q   <= 1'b0;
      h2_alt_q   <= 1'b0;
    end else begin
      have_pol_q <= have_pol_d;
      last_neg_q <= last_neg_d;
      h1_q       <= h1_d;
      h2_q       <= h2_d;
      h1_alt_q   <= h1_alt_d;
      h2_alt_q   <= h2_alt_d;
    end
  end

endmodule

// File: rtl/bpd_delay.sv
module bpd_delay #(
  parameter int DEPTH   = 3,
  parameter int CLR_TAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  input  logic clr,
  output logic dout
);

  logic [DEPTH-1:0] line_q, line_d;
  logic             dout_q, dout_d;

  always_comb line_d[0] = en ? din : line_q[0];

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    localparam bit HIT = ((i - 1) == CLR_TAP);
    always_comb begin
      if (en) line_d[i] = line_q[i-1] & ~(clr & HIT);
      else    line_d[i] = line_q[i];
    end
  end

  always_comb dout_d = en ? line_q[DEPTH-1] : dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      dout_q <= 1'b0;
    end else begin
      line_q <= line_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/bipolar_decoder.sv
module bipolar_decoder
  import bpd_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_en,
  input  logic rail_p,
  input  logic rail_n,
  input  logic mode_b3zs,
  output logic data_out,
  output logic data_vld,
  output logic viol_out
);

  localparam int FILL_W  = $clog2(LAT + 1);
  localparam int CLR_TAP = 1; // B of a B0V sits two symbols behind the V

  sym_kind_t kind;
  logic      bit_dec, viol_now, clr_back;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic      vld_q, vld_d, viol_q, viol_d;

  bpd_classify u_cls (
    .rail_p (rail_p),
    .rail_n (rail_n),
    .kind   (kind)
  );

  bpd_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_en    (sym_en),
    .mode_b3zs (mode_b3zs),
    .kind      (kind),
    .bit_dec   (bit_dec),
    .viol_now  (viol_now),
    .clr_back  (clr_back)
  );

  bpd_delay #(.DEPTH(LAT), .CLR_TAP(CLR_TAP)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sym_en),
    .din   (bit_dec),
    .clr   (clr_back),
    .dout  (data_out)
  );

  always_comb begin
    fill_d = fill_q;
    if (sym_en && (fill_q != FILL_W'(LAT))) fill_d = fill_q + 1'b1;
    vld_d  = sym_en && (fill_q == FILL_W'(LAT));
    viol_d = sym_en && viol_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      vld_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      fill_q <= fill_d;
      vld_q  <= vld_d;
      viol_q <= viol_d;
    end
  end

  assign data_vld = vld_q;
  assign viol_out = viol_q;

endmodule

// File: rtl/bpd_checker.sv
module bpd_checker (
  input logic clk,
  input logic rst_n,
  input logic sym_en,
  input logic rail_p,
  input logic rail_n,
  input logic data_out,
  input logic data_vld,
  input logic viol_out
);

  logic past_ok;
  logic mark_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok   <= 1'b0;
      mark_seen <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (sym_en && (rail_p ^ rail_n)) mark_seen <= 1'b1;
    end
  end

  p_quiet_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(sym_en)) |-> ($stable(data_out) && !data_vld && !viol_out));

  p_vld_follows_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && data_vld) |-> $past(sym_en));

  p_viol_follows_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && viol_out) |-> $past(sym_en));

  p_both_rails_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(sym_en && rail_p && rail_n)) |-> viol_out);

  p_first_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(sym_en && (rail_p ^ rail_n) && !mark_seen)) |-> !viol_out);

endmodule

bind bipolar_decoder bpd_checker u_bpd_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sym_en   (sym_en),
  .rail_p   (rail_p),
  .rail_n   (rail_n),
  .data_out (data_out),
  .data_vld (data_vld),
  .viol_out (viol_out)
);

// File: tb/bipolar_decoder_test.sv
`timescale 1ns/1ps
module bipolar_decoder_test;

  localparam int MAXS = 6000;

  logic clk = 1'b0;
  logic rst_n, sym_en, rail_p, rail_n, mode_b3zs;
  logic data_out, data_vld, viol_out;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  int  k = 0;
  bit  bit_m [MAXS];
  int  kind_m[MAXS];   // 0 space, 1 pos, 2 neg, 3 both
  bit  alt_m [MAXS];
  bit  m_have = 0;
  bit  m_neg  = 0;
  bit  last_dout = 0;

  always #2 clk = ~clk;

  bipolar_decoder uut (
    .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .rail_p(rail_p),
    .rail_n(rail_n), .mode_b3zs(mode_b3zs), .data_out(data_out),
    .data_vld(data_vld), .viol_out(viol_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d (symbol %0d)", tag, act, exp, k);
    end
  endtask

  // expected violation for the new symbol; updates model arrays
  function automatic bit model(input bit p, input bit n, input bit md);
    bit v = 0;
    int kd = p && n ? 3 : p ? 1 : n ? 2 : 0;
    kind_m[k] = kd;
    alt_m[k]  = 0;
    if (kd == 3) begin
      bit_m[k] = 1; v = 1;
    end else if (kd == 0) begin
      bit_m[k] = 0;
    end else begin
      bit neg = (kd == 2);
      if (!m_have || neg != m_neg) begin
        bit_m[k] = 1; alt_m[k] = 1;
      end else begin
        int h1 = (k >= 1) ? kind_m[k-1] : 0;
        int h2 = (k >= 2) ? kind_m[k-2] : 0;
        bit a2 = (k >= 2) ? alt_m[k-2] : 0;
        if (md && h1 == 0 && h2 == 0) begin
          bit_m[k] = 0;                     // 00V
        end else if (md && h1 == 0 && a2) begin
          bit_m[k] = 0; bit_m[k-2] = 0;     // B0V
        end else begin
          bit_m[k] = 1; v = 1;
        end
      end
      m_have = 1; m_neg = neg;
    end
    return v;
  endfunction

  task automatic send(input bit p, input bit n, input bit md, input string tag);
    bit ev;
    @(negedge clk);
    sym_en = 1; rail_p = p; rail_n = n; mode_b3zs = md;
    ev = model(p, n, md);
    @(posedge clk); #1;
    chk(viol_out == ev, {tag, " viol"}, viol_out, ev);
    if (k >= 3) begin
      chk(data_vld == 1'b1, "R3 vld", data_vld, 1);
      chk(data_out == bit_m[k-3], {tag, " data"}, data_out, bit_m[k-3]);
    end else begin
      chk(data_vld == 1'b0, "R3 vld early", data_vld, 0);
    end
    last_dout = data_out;
    k++;
  endtask

  task automatic idle(input int cyc);
    @(negedge clk);
    sym_en = 0; rail_p = $urandom_range(1); rail_n = $urandom_range(1);
    mode_b3zs = $urandom_range(1);
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); #1;
      chk(data_out == last_dout && !data_vld && !viol_out, "R10 idle",
          {data_out, data_vld, viol_out}, {last_dout, 2'b00});
    end
  endtask

  // B3ZS encoder for random data
  bit enc_p[$], enc_n[$];
  task automatic encode(input int nbits);
    bit d[];
    bit lneg = 1;
    int nb = 0;
    int i = 0;
    d = new[nbits];
    foreach (d[j]) d[j] = ($urandom_range(99) < 40);
    d[0] = 1;
    enc_p.delete(); enc_n.delete();
    while (i < nbits) begin
      if (i + 2 < nbits && !d[i] && !d[i+1] && !d[i+2]) begin
        if (nb % 2 == 1) begin
          enc_p.push_back(0); enc_n.push_back(0);
          enc_p.push_back(0); enc_n.push_back(0);
        end else begin
          lneg = !lneg;
          enc_p.push_back(!lneg); enc_n.push_back(lneg);
          enc_p.push_back(0); enc_n.push_back(0);
        end
        enc_p.push_back(!lneg); enc_n.push_back(lneg);
        nb = 0; i += 3;
      end else if (d[i]) begin
        lneg = !lneg;
        enc_p.push_back(!lneg); enc_n.push_back(lneg);
        nb++; i++;
      end else begin
        enc_p.push_back(0); enc_n.push_back(0);
        i++;
      end
    end
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b1a));
    rst_n = 0; sym_en = 0; rail_p = 0; rail_n = 0; mode_b3zs = 0;
    repeat (3) @(posedge clk);
    #1 chk(!data_out && !data_vld && !viol_out, "R1 in reset",
           {data_out, data_vld, viol_out}, 0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    chk(!data_out && !data_vld && !viol_out, "R1 after release",
        {data_out, data_vld, viol_out}, 0);

    // R6: first mark negative, no violation; then AMI stream (R2)
    send(0, 1, 0, "R6 first mark");
    send(1, 0, 0, "R2 alt");
    send(0, 0, 0, "R2 space");
    send(0, 1, 0, "R2 alt");
    idle(2);
    // R4: AMI repeat
    send(0, 1, 0, "R4 ami repeat");
    send(0, 0, 0, "R4 space");
    send(0, 0, 0, "R4 space");
    send(0, 1, 0, "R4 ami no subst");
    // R5: both rails, polarity kept (next pos alternates from neg)
    send(1, 1, 1, "R5 both rails");
    send(1, 0, 1, "R5 alt after both");
    // R7: 00V in B3ZS (last pos)
    send(0, 0, 1, "R7 space");
    send(0, 0, 1, "R7 space");
    send(1, 0, 1, "R7 00V");
    // R8: B0V (B neg, then V neg)
    send(0, 1, 1, "R8 B");
    send(0, 0, 1, "R8 zero");
    send(0, 1, 1, "R8 V");
    // R9: repeat without proper pattern
    send(1, 0, 1, "R9 alt");
    send(1, 0, 1, "R9 bad repeat");
    send(0, 0, 1, "R9 space");
    send(1, 0, 1, "R9 repeat after one space");
    // flush
    for (int i = 0; i < 4; i++) send(0, 0, 1, "R2 flush");

    // random raw rails, both modes, with gaps (R2 R4 R5 R9 R10)
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom_range(99);
      bit p = (r < 30) || (r >= 95);
      bit n = (r >= 30 && r < 60) || (r >= 95);
      send(p, n, i >= 750, "R9 random");
      if ($urandom_range(7) == 0) idle($urandom_range(1, 3));
    end

    // encoded B3ZS stream: substitutions throughout (R7 R8)
    encode(2500);
    for (int i = 0; i < enc_p.size(); i++) begin
      send(enc_p[i], enc_n[i], 1, "R8 encoded");
      if ($urandom_range(15) == 0) idle($urandom_range(1, 2));
    end
    for (int i = 0; i < 4; i++) send(0, 0, 1, "R2 flush");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule